// File: doc/BRIEF.md
# Dual-Pipeline In-Order Instruction Issue Unit

This block sits between an instruction fetch stage and two execution pipelines, named even and odd. Fetch hands it a whole line of up to 32 instructions in one cycle. The issue logic looks at the two oldest instructions not yet issued and sends out up to two of them per cycle. Each instruction carries a unit-class code. The code fixes which pipeline runs the instruction, so two instructions go out together only when one of them belongs to each pipe.

Issue stays strictly in program order. An internal scoreboard marks a destination register busy for the execution latency of its class. An external per-register ready vector lets other logic hold operands back, for example for outstanding loads. An instruction issues in the first cycle in which all its sources are ready. A flush discards the line. When the line is used up, the block requests a new one and stops issuing until it arrives.

Instruction word (25 bits): bits [2:0] unit class, [9:3] destination register, [16:10] source A, [23:17] source B, and bit [24] set when the instruction writes its destination. A line is packed with slot k at bits [25k+24:25k].

Top module: `dual_pipe_issue`

## Requirements
- R1: Class codes 0 (floating point) and 1 (fixed-point arithmetic/logic) issue only on the even port. Codes 2 (permute), 3 (load/store), 4 (branch), 5 (channel) and the unused codes 6 and 7 issue only on the odd port. At most one instruction leaves on each port per cycle.
- R2: Two instructions issue in the same cycle, each on its own pipe's port, when the two oldest instructions target different pipes, are both ready, and the younger one does not read the older one's destination. Either program order of even and odd is accepted.
- R3: When the two oldest instructions target the same pipe, only the older one issues. The younger one issues in a later cycle as the new oldest.
- R4: Issue is in program order. While the oldest instruction is not ready, nothing issues, even if the younger one is ready.
- R5: A source is ready when its bit in `reg_ready` is 1 and the scoreboard does not hold that register busy. An instruction issues in the same cycle its last source becomes ready.
- R6: An issued instruction with bit 24 set makes its destination busy. A dependent instruction can issue no earlier than L cycles after the producer, with L = 6 for codes 0 and 3, 2 for codes 1, 4, 6 and 7, 4 for code 2, and 7 for code 5.
- R7: A younger instruction that reads the older one's destination is not paired with it. It waits for the scoreboard instead.
- R8: In a cycle with `flush` high, nothing issues, the line is discarded (`refill_req` is high in the next cycle), and a load offered in that cycle is ignored.
- R9: `refill_req` is high exactly when no unissued instruction remains, including after reset. While it is high nothing issues. A load is accepted only while `refill_req` is high and is ignored otherwise.
- R10: The window never reaches past the loaded count. The last instruction of a line issues alone, and slots at or above `line_count` never issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_load | input | 1 | Offer a new instruction line |
| line_data | input | 800 | 32 packed 25-bit instruction slots |
| line_count | input | 6 | Number of valid slots in the offered line (1..32) |
| flush | input | 1 | Discard the line and suppress issue this cycle |
| reg_ready | input | 128 | External per-register operand ready bits |
| refill_req | output | 1 | Line used up; a new line is needed |
| even_valid | output | 1 | An instruction issues on the even pipe |
| even_insn | output | 25 | Instruction issued on the even pipe |
| odd_valid | output | 1 | An instruction issues on the odd pipe |
| odd_insn | output | 25 | Instruction issued on the odd pipe |

## Verification
Pairs are tried in both orders (even then odd, odd then even) and against a same-pipe pair. This separates pipe-split pairing from merely taking two slots, and it shows the younger instruction moving up into the window. A stalled oldest instruction with a ready younger one separates in-order issue from out-of-order issue. A chain of producers with latencies 2 and 6 pins the scoreboard timing to the exact cycle, and one of those producers sits in the same window as its consumer. A short line with a stale ready slot beyond its count, plus loads offered while the line is busy and during a flush, separate count-bounded issue and refill gating from careless reuse of the buffer.

// File: rtl/issue_pkg.sv
package issue_pkg;
  localparam int REG_W  = 7;
  localparam int NREG   = 1 << REG_W;
  localparam int LAT_W  = 3;

  typedef enum logic [2:0] {
    CL_FLT  = 3'd0,
    CL_ALU  = 3'd1,
    CL_PERM = 3'd2,
    CL_MEM  = 3'd3,
    CL_BRN  = 3'd4,
    CL_CHN  = 3'd5
  } ucls_e;

  typedef struct packed {
    logic             wr;
    logic [REG_W-1:0] src_b;
    logic [REG_W-1:0] src_a;
    logic [REG_W-1:0] dst;
    ucls_e            cls;
  } insn_t;

  localparam int INSN_W = $bits(insn_t);

  function automatic logic on_even(input ucls_e c);
    return (c == CL_FLT) || (c == CL_ALU);
  endfunction

  function automatic logic [LAT_W-1:0] class_lat(input ucls_e c);
    case (c)
      CL_FLT:  return 3'd6;
      CL_ALU:  return 3'd2;
      CL_PERM: return 3'd4;
      CL_MEM:  return 3'd6;
      CL_BRN:  return 3'd2;
      CL_CHN:  return 3'd7;
      default: return 3'd2;
    endcase
  endfunction

  function automatic logic srcs_ready(input insn_t x, input logic [NREG-1:0] rdy);
    return rdy[x.src_a] && rdy[x.src_b];
  endfunction

  function automatic logic reads_dst(input insn_t older, input insn_t younger);
    return older.wr && ((younger.src_a == older.dst) || (younger.src_b == older.dst));
  endfunction
endpackage

// File: rtl/issue_linebuf.sv
module issue_linebuf
  import issue_pkg::*;
#(
  parameter int SLOTS = 32,
  localparam int CNT_W = $clog2(SLOTS + 1),
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    load,
  input  logic [SLOTS*INSN_W-1:0] load_data,
  input  logic [CNT_W-1:0]        load_cnt,
  input  logic [1:0]              adv,
  output insn_t                   slot0,
  output insn_t                   slot1,
  output logic                    v0,
  output logic                    v1,
  output logic                    empty
);
  insn_t            mem [SLOTS];
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] ptr;
  logic [CNT_W:0]   ptr_nx1;
  logic             load_take;
  logic [IDX_W-1:0] idx0;
  logic [IDX_W-1:0] idx1;

  assign ptr_nx1   = {1'b0, ptr} + 1'b1;
  assign v0        = ptr < cnt;
  assign v1        = ptr_nx1 < {1'b0, cnt};
  assign empty     = !v0;
  assign load_take = load && empty && !flush;
  assign idx0      = ptr[IDX_W-1:0];
  assign idx1      = ptr_nx1[IDX_W-1:0];
  assign slot0     = mem[idx0];
  assign slot1     = mem[idx1];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      cnt <= '0;
      ptr <= '0;
    end else if (load_take) begin
      cnt <= load_cnt;
      ptr <= '0;
    end else begin
      ptr <= ptr + CNT_W'(adv);
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (load_take) mem[g] <= insn_t'(load_data[g*INSN_W +: INSN_W]);
    end
  end
endmodule

// File: rtl/issue_scoreboard.sv
module issue_scoreboard
  import issue_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr0_en,
  input  logic [REG_W-1:0] wr0_reg,
  input  logic [LAT_W-1:0] wr0_lat,
  input  logic             wr1_en,
  input  logic [REG_W-1:0] wr1_reg,
  input  logic [LAT_W-1:0] wr1_lat,
  output logic [NREG-1:0]  busy
);
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [LAT_W-1:0] left;
    assign busy[r] = (left != '0);
    always_ff @(posedge clk) begin
      if (!rst_n)                                 left <= '0;
      else if (wr1_en && wr1_reg == REG_W'(r))    left <= wr1_lat - 1'b1;
      else if (wr0_en && wr0_reg == REG_W'(r))    left <= wr0_lat - 1'b1;
      else if (left != '0)                        left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/issue_pair.sv
module issue_pair
  import issue_pkg::*;
(
  input  insn_t           slot0,
  input  insn_t           slot1,
  input  logic            v0,
  input  logic            v1,
  input  logic            hold,
  input  logic [NREG-1:0] op_ready,
  output logic            take0,
  output logic            take1,
  output logic [1:0]      adv,
  output logic            even_v,
  output insn_t           even_i,
  output logic            odd_v,
  output insn_t           odd_i
);
  logic e0, e1, split, raw;

  assign e0    = on_even(slot0.cls);
  assign e1    = on_even(slot1.cls);
  assign split = e0 != e1;
  assign raw   = reads_dst(slot0, slot1);
  assign take0 = v0 && !hold && srcs_ready(slot0, op_ready);
  assign take1 = take0 && v1 && split && !raw && srcs_ready(slot1, op_ready);
  assign adv   = take1 ? 2'd2 : (take0 ? 2'd1 : 2'd0);

  assign even_v = (take0 && e0) || (take1 && e1);
  assign odd_v  = (take0 && !e0) || (take1 && !e1);
  assign even_i = (take0 && e0) ? slot0 : slot1;
  assign odd_i  = (take0 && !e0) ? slot0 : slot1;
endmodule

// File: rtl/dual_pipe_issue.sv
module dual_pipe_issue
  import issue_pkg::*;
#(
  parameter int LINE_SLOTS = 32,
  localparam int CNT_W = $clog2(LINE_SLOTS + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         line_load,
  input  logic [LINE_SLOTS*INSN_W-1:0] line_data,
  input  logic [CNT_W-1:0]             line_count,
  input  logic                         flush,
  input  logic [NREG-1:0]              reg_ready,
  output logic                         refill_req,
  output logic                         even_valid,
  output logic [INSN_W-1:0]            even_insn,
  output logic                         odd_valid,
  output logic [INSN_W-1:0]            odd_insn
);
  insn_t           slot0, slot1, even_i, odd_i;
  logic            v0, v1, empty, take0, take1;
  logic [1:0]      adv;
  logic [NREG-1:0] sb_busy;
  logic [NREG-1:0] op_ready;

  assign op_ready = reg_ready & ~sb_busy;

  issue_linebuf #(.SLOTS(LINE_SLOTS)) u_buf (
    .clk(clk), .rst_n(rst_n), .flush(flush), .load(line_load),
    .load_data(line_data), .load_cnt(line_count), .adv(adv),
    .slot0(slot0), .slot1(slot1), .v0(v0), .v1(v1), .empty(empty)
  );

  issue_pair u_pair (
    .slot0(slot0), .slot1(slot1), .v0(v0), .v1(v1), .hold(flush),
    .op_ready(op_ready), .take0(take0), .take1(take1), .adv(adv),
    .even_v(even_valid), .even_i(even_i), .odd_v(odd_valid), .odd_i(odd_i)
  );

  issue_scoreboard u_sb (
    .clk(clk), .rst_n(rst_n),
    .wr0_en(take0 && slot0.wr), .wr0_reg(slot0.dst), .wr0_lat(class_lat(slot0.cls)),
    .wr1_en(take1 && slot1.wr), .wr1_reg(slot1.dst), .wr1_lat(class_lat(slot1.cls)),
    .busy(sb_busy)
  );

  assign refill_req = empty;
  assign even_insn  = even_i;
  assign odd_insn   = odd_i;
endmodule

// File: rtl/dual_pipe_issue_chk.sv
module dual_pipe_issue_chk
  import issue_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              refill_req,
  input logic              even_valid,
  input logic [INSN_W-1:0] even_insn,
  input logic              odd_valid,
  input logic [INSN_W-1:0] odd_insn,
  input logic [NREG-1:0]   sb_busy
);
  insn_t ev, od;
  assign ev = insn_t'(even_insn);
  assign od = insn_t'(odd_insn);

  AST_EVEN_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    even_valid |-> on_even(ev.cls)); // R1
  AST_ODD_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    odd_valid |-> !on_even(od.cls)); // R1
  AST_EVEN_SRC_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    even_valid |-> (!sb_busy[ev.src_a] && !sb_busy[ev.src_b])); // R5
  AST_ODD_SRC_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    odd_valid |-> (!sb_busy[od.src_a] && !sb_busy[od.src_b])); // R5
  AST_EVEN_DST_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (even_valid && ev.wr) |=> sb_busy[$past(ev.dst)]); // R6
  AST_ODD_DST_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (odd_valid && od.wr) |=> sb_busy[$past(od.dst)]); // R6
  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!even_valid && !odd_valid)); // R8
  AST_FLUSH_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> refill_req); // R8
  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    refill_req |-> (!even_valid && !odd_valid)); // R9
endmodule

bind dual_pipe_issue dual_pipe_issue_chk u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .refill_req(refill_req),
  .even_valid(even_valid), .even_insn(even_insn),
  .odd_valid(odd_valid), .odd_insn(odd_insn), .sb_busy(sb_busy)
);

// File: tb/tb_dual_pipe_issue.sv
module tb_dual_pipe_issue;
  localparam int SL = 32;
  localparam int IW = 25;

  logic             clk = 0;
  logic             rst_n = 0;
  logic             line_load = 0;
  logic [SL*IW-1:0] line_data = '0;
  logic [5:0]       line_count = '0;
  logic             flush = 0;
  logic [127:0]     reg_ready = '1;
  logic             refill_req, even_valid, odd_valid;
  logic [IW-1:0]    even_insn, odd_insn;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  dual_pipe_issue dut (
    .clk(clk), .rst_n(rst_n), .line_load(line_load), .line_data(line_data),
    .line_count(line_count), .flush(flush), .reg_ready(reg_ready),
    .refill_req(refill_req), .even_valid(even_valid), .even_insn(even_insn),
    .odd_valid(odd_valid), .odd_insn(odd_insn)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // word: [24] wr, [23:17] srcB, [16:10] srcA, [9:3] dst, [2:0] class
  function automatic logic [IW-1:0] mk(int c, int d, int a, int b, bit w);
    return {w, 7'(b), 7'(a), 7'(d), 3'(c)};
  endfunction

  task automatic put(int k, logic [IW-1:0] w);
    line_data[k*IW +: IW] = w;
  endtask

  task automatic do_load(int n);
    @(negedge clk);
    line_load = 1; line_count = 6'(n);
    @(negedge clk);
    line_load = 0;
    #2;
  endtask

  task automatic nxt;
    @(negedge clk);
    #2;
  endtask

  task automatic expect_iss(string tag, bit ev, logic [IW-1:0] ei, bit ov, logic [IW-1:0] oi);
    total++;
    if (even_valid !== ev || odd_valid !== ov || (ev && even_insn !== ei) || (ov && odd_insn !== oi)) begin
      bad++;
      $display("FAIL %s: actual ev=%0b ei=%h ov=%0b oi=%h expected ev=%0b ei=%h ov=%0b oi=%h",
               tag, even_valid, even_insn, odd_valid, odd_insn, ev, ei, ov, oi);
    end
  endtask

  task automatic expect_refill(string tag, bit r);
    total++;
    if (refill_req !== r) begin
      bad++;
      $display("FAIL %s: actual refill_req=%0b expected %0b", tag, refill_req, r);
    end
  endtask

  task automatic t_reset;
    expect_refill("R9 reset refill", 1);
    expect_iss("R9 reset quiet", 0, '0, 0, '0);
  endtask

  task automatic t_pair;
    logic [IW-1:0] a, b;
    a = mk(1, 1, 40, 41, 1); b = mk(3, 2, 42, 43, 1);
    put(0, a); put(1, b);
    do_load(2);
    expect_refill("R9 loaded", 0);
    expect_iss("R2 even-odd pair", 1, a, 1, b);
    nxt;
    expect_refill("R9 drained", 1);
    expect_iss("R9 empty quiet", 0, '0, 0, '0);
    a = mk(4, 3, 44, 45, 0); b = mk(0, 4, 46, 47, 1);
    put(0, a); put(1, b);
    do_load(2);
    expect_iss("R2 odd-even pair R1 routing", 1, b, 1, a);
    a = mk(6, 5, 48, 49, 0); b = mk(1, 6, 48, 49, 1);
    put(0, a); put(1, b);
    nxt;
    do_load(2);
    expect_iss("R1 spare code on odd", 1, b, 1, a);
    nxt;
  endtask

  task automatic t_same;
    logic [IW-1:0] a, b, c;
    a = mk(0, 8, 50, 51, 1); b = mk(1, 9, 52, 53, 1); c = mk(2, 10, 54, 55, 1);
    put(0, a); put(1, b); put(2, c);
    do_load(3);
    expect_iss("R3 same pipe older only", 1, a, 0, '0);
    nxt;
    expect_iss("R3 younger moves up and pairs", 1, b, 1, c);
    nxt;
    expect_refill("R9 after same", 1);
  endtask

  task automatic t_stall;
    logic [IW-1:0] a, b;
    a = mk(1, 11, 70, 56, 1); b = mk(3, 12, 57, 58, 1);
    put(0, a); put(1, b);
    reg_ready[70] = 1'b0;
    do_load(2);
    expect_iss("R4 old not ready none", 0, '0, 0, '0);
    nxt;
    expect_iss("R4 still held", 0, '0, 0, '0);
    reg_ready[70] = 1'b1;
    #1;
    expect_iss("R5 issue in ready cycle", 1, a, 1, b);
    nxt;
    expect_refill("R9 after stall", 1);
  endtask

  task automatic t_sb;
    logic [IW-1:0] a, b, c, d;
    a = mk(1, 20, 60, 61, 1);
    b = mk(1, 21, 20, 62, 1);
    c = mk(0, 22, 63, 63, 1);
    d = mk(2, 23, 22, 64, 1);
    put(0, a); put(1, b); put(2, c); put(3, d);
    do_load(4);
    expect_iss("R3 sb first", 1, a, 0, '0);
    nxt;
    expect_iss("R6 lat2 busy", 0, '0, 0, '0);
    nxt;
    expect_iss("R6 lat2 expired", 1, b, 0, '0);
    nxt;
    expect_iss("R7 raw not paired", 1, c, 0, '0);
    for (int k = 1; k <= 5; k++) begin
      nxt;
      expect_iss($sformatf("R6 lat6 busy +%0d", k), 0, '0, 0, '0);
    end
    nxt;
    expect_iss("R6 lat6 expired", 0, '0, 1, d);
    nxt;
    expect_refill("R9 after sb", 1);
  endtask

  task automatic t_flush;
    for (int k = 0; k < 4; k++) put(k, mk(1, 0, 80 + k, 80 + k, 0));
    do_load(4);
    expect_iss("R8 before flush", 1, mk(1, 0, 80, 80, 0), 0, '0);
    nxt;
    flush = 1; line_load = 1; line_count = 6'd4;
    #1;
    expect_iss("R8 flush cycle quiet", 0, '0, 0, '0);
    @(negedge clk);
    flush = 0; line_load = 0;
    #2;
    expect_refill("R8 flushed empty load ignored", 1);
    expect_iss("R8 post flush quiet", 0, '0, 0, '0);
  endtask

  task automatic t_ignore;
    logic [IW-1:0] a, b, c;
    a = mk(0, 30, 90, 91, 0); b = mk(1, 31, 92, 93, 0); c = mk(1, 32, 94, 95, 0);
    put(0, a); put(1, b); put(2, c);
    do_load(3);
    expect_iss("R3 ignore first", 1, a, 0, '0);
    put(0, mk(2, 33, 96, 96, 0)); put(1, mk(3, 34, 97, 97, 0));
    line_load = 1; line_count = 6'd2;
    @(negedge clk);
    line_load = 0;
    #2;
    expect_iss("R9 busy load ignored", 1, b, 0, '0);
    nxt;
    expect_iss("R9 original line kept", 1, c, 0, '0);
    nxt;
    expect_refill("R9 after ignore", 1);
  endtask

  task automatic t_tail;
    logic [IW-1:0] a, b, c, s;
    a = mk(1, 40, 100, 101, 0); b = mk(3, 41, 102, 103, 0);
    c = mk(2, 42, 104, 105, 0); s = mk(1, 43, 106, 107, 0);
    put(0, a); put(1, b); put(2, c); put(3, s);
    do_load(3);
    expect_iss("R10 head pair", 1, a, 1, b);
    nxt;
    expect_iss("R10 last alone", 0, '0, 1, c);
    nxt;
    expect_refill("R10 stale slot unused", 1);
    expect_iss("R10 stale slot quiet", 0, '0, 0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    t_reset;
    t_pair;
    t_same;
    t_stall;
    t_sb;
    t_flush;
    t_ignore;
    t_tail;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule